// File: doc/BRIEF.md
# Post-Update Load Unit

This unit carries out one register-based load at a time. The load reads memory at the address held in the base register, exactly as it is. Only after that read does the base register advance. The unit takes an already-decoded operation. The operation carries an access size, a flag choosing sign or zero extension, a flag choosing immediate or indexed form, the target and base register numbers, the base and index register values, and a 16-bit immediate.

For a legal operation, the unit sends one request on a valid/ready read port and waits for the one-beat response. It then writes back two registers in the same cycle. The target register receives the extended load data. The base register receives its old value plus the increment. An operation whose register fields make it an invalid form is refused: the unit raises an illegal flag and touches neither memory nor the register file.

Top module: `postinc_load_unit`

## Requirements
- R1: The address on `mem_req_addr` equals the `op_base` value that was accepted, with no offset added. While `mem_req_valid` is high and `mem_req_ready` is low, the address and size hold steady.
- R2: The size code is 0 for a byte, 1 for a halfword, 2 for a word and 3 for a doubleword. The accepted code appears unchanged on `mem_req_size`.
- R3: The loaded bytes sit right-justified in `mem_rsp_data`, in bits [8N-1:0] for an N-byte access. When `op_sign` is 0, every bit of `wb_rt_data` above the loaded bytes is zero, whatever the response carries there.
- R4: When `op_sign` is 1, the loaded byte, halfword or word is sign-extended to 64 bits. For a doubleword, `op_sign` has no effect.
- R5: In immediate form (`op_indexed`=0) with a size other than doubleword, `wb_ra_data` equals the base plus the sign-extended 16-bit immediate.
- R6: In immediate form with a doubleword size, immediate bits [1:0] are ignored. `wb_ra_data` equals the base plus the sign extension of {imm[15:2], 2'b00}.
- R7: In indexed form (`op_indexed`=1), `wb_ra_data` equals the base plus `op_index`, and the immediate has no effect.
- R8: An operation with `op_ra`=0, or with `op_ra`=`op_rt`, is illegal. In the cycle after it is accepted, `illegal` is high for one cycle. No memory request is made and neither writeback enable rises.
- R9: `wb_rt_en` and `wb_ra_en` are high together for exactly one cycle, the cycle after the cycle in which `mem_rsp_valid` was high. They carry `wb_rt_idx`=`op_rt` and `wb_ra_idx`=`op_ra`.
- R10: `op_ready` is high only while the unit is idle. After a legal operation is accepted, `op_ready` stays low through the writeback cycle and returns high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Decoded operation present |
| op_ready | output | 1 | Unit idle and able to accept |
| op_size | input | 2 | Access size code |
| op_sign | input | 1 | 1 = sign-extend, 0 = zero-extend |
| op_indexed | input | 1 | 1 = increment from op_index, 0 = from immediate |
| op_rt | input | 5 | Target register number |
| op_ra | input | 5 | Base register number |
| op_base | input | 64 | Base register value |
| op_index | input | 64 | Index register value |
| op_imm | input | 16 | Immediate displacement |
| illegal | output | 1 | Invalid-form pulse |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-justified |
| wb_rt_en | output | 1 | Target writeback enable |
| wb_rt_idx | output | 5 | Target writeback register |
| wb_rt_data | output | 64 | Extended load result |
| wb_ra_en | output | 1 | Base writeback enable |
| wb_ra_idx | output | 5 | Base writeback register |
| wb_ra_data | output | 64 | Updated base value |

## Verification
The operation fields and the computed new base are latched when the operation is accepted. A corrupted latch therefore shows at the ports within one operation, as a wrong address or size on the request, or as a wrong index or value at writeback. A wrong state in the sequencer shows up at once: `op_ready` is high while a request is outstanding, a request is lost, or only one of the two writeback enables is raised. Each of these is visible within one or two cycles of the response. An error in the legality path shows on the next cycle, as a missing illegal pulse or as a memory request made for a refused form.

// File: rtl/plu_pkg.sv
package plu_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } ld_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_WB   = 2'd3
   } seq_state_e;

endpackage

// File: rtl/plu_form_check.sv
module plu_form_check #(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] rt,
   input  logic [IDX_W-1:0] ra,
   output logic             bad_form
);
   logic base_is_zero;
   logic base_is_target;

   always_comb begin
      base_is_zero   = (ra == '0);
      base_is_target = (ra == rt);
      bad_form       = base_is_zero | base_is_target;
   end
endmodule

// File: rtl/plu_incr.sv
module plu_incr #(
   parameter int XLEN  = 64,
   parameter int IMM_W = 16
) (
   input  logic [XLEN-1:0]  base,
   input  logic [XLEN-1:0]  index,
   input  logic [IMM_W-1:0] imm,
   input  logic             indexed,
   input  logic             dbl_form,
   output logic [XLEN-1:0]  next_base
);
   localparam int EXT_W = XLEN - IMM_W;

   logic [IMM_W-1:0] imm_eff;
   logic [XLEN-1:0]  imm_sx;
   logic [XLEN-1:0]  step;

   always_comb begin
      // doubleword immediate form: displacement is a multiple of four
      imm_eff   = dbl_form ? {imm[IMM_W-1:2], 2'b00} : imm;
      imm_sx    = {{EXT_W{imm_eff[IMM_W-1]}}, imm_eff};
      step      = indexed ? index : imm_sx;
      next_base = base + step;
   end
endmodule

// File: rtl/plu_extend.sv
module plu_extend
   import plu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  ld_size_e         size,
   input  logic             sign,
   input  logic [XLEN-1:0]  raw,
   output logic [XLEN-1:0]  result
);
   localparam int N_SZ = 4;

   logic [XLEN-1:0] cand [N_SZ];

   for (genvar s = 0; s < N_SZ; s++) begin : g_sz
      localparam int W = 8 << s;
      if (W >= XLEN) begin : g_full
         assign cand[s] = raw;
      end else begin : g_part
         logic fill;
         assign fill    = sign & raw[W-1];
         assign cand[s] = {{(XLEN-W){fill}}, raw[W-1:0]};
      end
   end

   always_comb begin
      result = cand[size];
   end
endmodule

// File: rtl/postinc_load_unit.sv
module postinc_load_unit
   import plu_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IDX_W = 5,
   parameter int IMM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   output logic             op_ready,
   input  logic [1:0]       op_size,
   input  logic             op_sign,
   input  logic             op_indexed,
   input  logic [IDX_W-1:0] op_rt,
   input  logic [IDX_W-1:0] op_ra,
   input  logic [XLEN-1:0]  op_base,
   input  logic [XLEN-1:0]  op_index,
   input  logic [IMM_W-1:0] op_imm,
   output logic             illegal,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [XLEN-1:0]  mem_req_addr,
   output logic [1:0]       mem_req_size,
   input  logic             mem_rsp_valid,
   input  logic [XLEN-1:0]  mem_rsp_data,
   output logic             wb_rt_en,
   output logic [IDX_W-1:0] wb_rt_idx,
   output logic [XLEN-1:0]  wb_rt_data,
   output logic             wb_ra_en,
   output logic [IDX_W-1:0] wb_ra_idx,
   output logic [XLEN-1:0]  wb_ra_data
);
   initial begin
      assert (XLEN == 64) else $error("XLEN must be 64");
      assert (IDX_W >= 1) else $error("IDX_W must be positive");
      assert (IMM_W >= 3 && IMM_W < XLEN) else $error("IMM_W out of range");
   end

   seq_state_e       state_q;
   ld_size_e         size_q;
   logic             sign_q;
   logic [IDX_W-1:0] rt_q, ra_q;
   logic [XLEN-1:0]  addr_q, nbase_q, raw_q;
   logic             illegal_q;

   logic             bad_form;
   logic [XLEN-1:0]  nbase_d;
   logic [XLEN-1:0]  ext_data;
   logic             accept;

   plu_form_check #(.IDX_W(IDX_W)) u_form (
      .rt       (op_rt),
      .ra       (op_ra),
      .bad_form (bad_form)
   );

   plu_incr #(.XLEN(XLEN), .IMM_W(IMM_W)) u_incr (
      .base      (op_base),
      .index     (op_index),
      .imm       (op_imm),
      .indexed   (op_indexed),
      .dbl_form  (op_size == SZ_DBL),
      .next_base (nbase_d)
   );

   plu_extend #(.XLEN(XLEN)) u_ext (
      .size   (size_q),
      .sign   (sign_q),
      .raw    (raw_q),
      .result (ext_data)
   );

   assign op_ready = (state_q == ST_IDLE);
   assign accept   = op_valid & op_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         illegal_q <= 1'b0;
         size_q    <= SZ_BYTE;
         sign_q    <= 1'b0;
         rt_q      <= '0;
         ra_q      <= '0;
         addr_q    <= '0;
         nbase_q   <= '0;
         raw_q     <= '0;
      end else begin
         illegal_q <= accept & bad_form;
         case (state_q)
            ST_IDLE: if (accept && !bad_form) begin
               state_q <= ST_REQ;
               size_q  <= ld_size_e'(op_size);
               sign_q  <= op_sign;
               rt_q    <= op_rt;
               ra_q    <= op_ra;
               addr_q  <= op_base;
               nbase_q <= nbase_d;
            end
            ST_REQ:  if (mem_req_ready) state_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               state_q <= ST_WB;
               raw_q   <= mem_rsp_data;
            end
            ST_WB:   state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign illegal       = illegal_q;
   assign mem_req_valid = (state_q == ST_REQ);
   assign mem_req_addr  = addr_q;
   assign mem_req_size  = size_q;
   assign wb_rt_en      = (state_q == ST_WB);
   assign wb_ra_en      = (state_q == ST_WB);
   assign wb_rt_idx     = rt_q;
   assign wb_ra_idx     = ra_q;
   assign wb_rt_data    = ext_data;
   assign wb_ra_data    = nbase_q;

   // R1: request fields hold while stalled
   p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size));

   // R10: no new operation accepted while a request is out
   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !op_ready);

   // R9: both writebacks together, right after a response
   p_wb_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_rt_en == wb_ra_en);
   p_wb_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_rt_en |-> $past(mem_rsp_valid));

   // R8: an illegal form touches neither memory nor registers
   p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !mem_req_valid && !wb_rt_en && !wb_ra_en);
   p_illegal_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $past(op_valid && op_ready));

   // R3: zero-extended byte clears all upper bits
   p_zero_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_rt_en && !sign_q && size_q == SZ_BYTE |-> wb_rt_data[XLEN-1:8] == '0);
endmodule

// File: tb/postinc_load_unit_tb_top.sv
module postinc_load_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_ready;
   logic [1:0]  op_size = '0;
   logic        op_sign = 1'b0;
   logic        op_indexed = 1'b0;
   logic [4:0]  op_rt = '0, op_ra = '0;
   logic [63:0] op_base = '0, op_index = '0;
   logic [15:0] op_imm = '0;
   logic        illegal;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [63:0] mem_req_addr;
   logic [1:0]  mem_req_size;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        wb_rt_en, wb_ra_en;
   logic [4:0]  wb_rt_idx, wb_ra_idx;
   logic [63:0] wb_rt_data, wb_ra_data;

   always #2 clk = ~clk;

   postinc_load_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_size(op_size), .op_sign(op_sign), .op_indexed(op_indexed),
      .op_rt(op_rt), .op_ra(op_ra), .op_base(op_base), .op_index(op_index),
      .op_imm(op_imm), .illegal(illegal), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_req_size(mem_req_size), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .wb_rt_en(wb_rt_en), .wb_rt_idx(wb_rt_idx),
      .wb_rt_data(wb_rt_data), .wb_ra_en(wb_ra_en), .wb_ra_idx(wb_ra_idx),
      .wb_ra_data(wb_ra_data)
   );

   typedef struct {
      logic        ill;
      logic [4:0]  rt, ra;
      logic [63:0] rtd, rad;
   } exp_t;

   typedef struct {
      logic [63:0] addr;
      logic [1:0]  size;
   } req_t;

   exp_t exp_q[$];
   req_t req_q[$];
   int checks = 0;
   int errors = 0;
   int cycles = 0;

   task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] memword(input logic [63:0] a);
      return {~a[31:0], a[31:0] ^ 32'h8000_8080};
   endfunction

   function automatic logic [63:0] extend(input logic [1:0] sz, input logic sg, input logic [63:0] w);
      case (sz)
         2'd0: return sg ? {{56{w[7]}}, w[7:0]}   : {56'b0, w[7:0]};
         2'd1: return sg ? {{48{w[15]}}, w[15:0]} : {48'b0, w[15:0]};
         2'd2: return sg ? {{32{w[31]}}, w[31:0]} : {32'b0, w[31:0]};
         default: return w;
      endcase
   endfunction

   task automatic do_op(input logic [1:0] sz, input logic sg, input logic idx,
                        input logic [4:0] rt, input logic [4:0] ra,
                        input logic [63:0] base, input logic [63:0] ix, input logic [15:0] imm);
      exp_t e;
      req_t r;
      logic [63:0] step;
      e.ill = (ra == 5'd0) || (ra == rt);
      e.rt  = rt;
      e.ra  = ra;
      e.rtd = extend(sz, sg, memword(base));
      if (idx) step = ix;
      else if (sz == 2'd3) step = {{48{imm[15]}}, imm[15:2], 2'b00};
      else step = {{48{imm[15]}}, imm};
      e.rad = base + step;
      exp_q.push_back(e);
      if (!e.ill) begin
         r.addr = base;
         r.size = sz;
         req_q.push_back(r);
      end
      @(negedge clk);
      while (!op_ready) @(negedge clk);
      op_valid = 1'b1; op_size = sz; op_sign = sg; op_indexed = idx;
      op_rt = rt; op_ra = ra; op_base = base; op_index = ix; op_imm = imm;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   // memory model
   initial begin
      logic        seen = 1'b0;
      logic        pend = 1'b0;
      int          lat = 0;
      int          stall = 0;
      int          k = 0;
      logic [63:0] acc_addr = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (mem_req_ready) begin
            mem_req_ready = 1'b0;
            seen = 1'b0;
            pend = 1'b1;
            lat = k % 2;
         end
         if (pend) begin
            if (lat == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = memword(acc_addr);
               pend = 1'b0;
            end else lat--;
         end
         if (mem_req_valid && !seen) begin
            seen = 1'b1;
            k++;
            stall = k % 3;
            acc_addr = mem_req_addr;
            if (req_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R8 unexpected request actual=%h expected=none", mem_req_addr);
            end else begin
               req_t r;
               r = req_q.pop_front();
               check64("R1 request address", mem_req_addr, r.addr);
               check64("R2 request size", {62'b0, mem_req_size}, {62'b0, r.size});
            end
         end
         if (mem_req_valid && seen) begin
            if (stall == 0) mem_req_ready = 1'b1;
            else begin
               stall--;
               check64("R1 address held in stall", mem_req_addr, acc_addr);
            end
         end
      end
   end

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && (illegal || wb_rt_en || wb_ra_en)) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R9 unexpected output actual=%b%b%b expected=000", illegal, wb_rt_en, wb_ra_en);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               if (e.ill) begin
                  check64("R8 illegal pulse", {63'b0, illegal}, 64'd1);
                  check64("R8 no writeback", {62'b0, wb_rt_en, wb_ra_en}, 64'd0);
                  check64("R8 no request", {63'b0, mem_req_valid}, 64'd0);
               end else begin
                  check64("R9 both enables", {62'b0, wb_rt_en, wb_ra_en}, 64'd3);
                  check64("R9 target index", {59'b0, wb_rt_idx}, {59'b0, e.rt});
                  check64("R9 base index", {59'b0, wb_ra_idx}, {59'b0, e.ra});
                  check64("R3/R4 target data", wb_rt_data, e.rtd);
                  check64("R5/R6/R7 base data", wb_ra_data, e.rad);
                  check64("R10 busy in writeback", {63'b0, op_ready}, 64'd0);
                  @(negedge clk);
                  check64("R9 single-cycle writeback", {62'b0, wb_rt_en, wb_ra_en}, 64'd0);
                  check64("R10 ready after writeback", {63'b0, op_ready}, 64'd1);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check64("R10 reset ready", {63'b0, op_ready}, 64'd1);
      check64("R9 reset outputs", {60'b0, mem_req_valid, wb_rt_en, wb_ra_en, illegal}, 64'd0);

      // R3 zero extension, R4 sign extension for each size; R5 immediates
      do_op(2'd0, 1'b0, 1'b0, 5'd3, 5'd4, 64'h1000, 64'h0, 16'h0001); // R3 byte 0x80 zero
      do_op(2'd0, 1'b1, 1'b0, 5'd3, 5'd4, 64'h1000, 64'h0, 16'hFFFF); // R4 byte negative, R5 -1
      do_op(2'd0, 1'b1, 1'b0, 5'd5, 5'd6, 64'h10C1, 64'h0, 16'h0010); // R4 byte positive
      do_op(2'd1, 1'b0, 1'b0, 5'd7, 5'd8, 64'h2000, 64'h0, 16'h8000); // R3 half, R5 min imm
      do_op(2'd1, 1'b1, 1'b0, 5'd7, 5'd8, 64'h2000, 64'h0, 16'h7FFF); // R4 half negative
      do_op(2'd2, 1'b0, 1'b0, 5'd9, 5'd1, 64'h0, 64'h0, 16'h0004);    // R3 word
      do_op(2'd2, 1'b1, 1'b0, 5'd9, 5'd1, 64'h0, 64'h0, 16'hFFFC);    // R4 word negative
      do_op(2'd2, 1'b1, 1'b0, 5'd9, 5'd1, 64'h8000_0000, 64'h0, 16'h0008); // R4 word positive
      // R6 doubleword immediate, low bits ignored; R4 sign no effect
      do_op(2'd3, 1'b0, 1'b0, 5'd10, 5'd11, 64'h3000, 64'h0, 16'h0007);
      do_op(2'd3, 1'b1, 1'b0, 5'd10, 5'd11, 64'h3000, 64'h0, 16'hFFF3);
      // R7 indexed, immediate ignored
      do_op(2'd1, 1'b0, 1'b1, 5'd12, 5'd13, 64'h4000, 64'h123, 16'hABCD);
      do_op(2'd3, 1'b1, 1'b1, 5'd12, 5'd13, 64'h4000, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0003);
      // R8 illegal forms
      do_op(2'd0, 1'b0, 1'b0, 5'd3, 5'd0, 64'h5000, 64'h0, 16'h0001);
      do_op(2'd2, 1'b0, 1'b1, 5'd14, 5'd14, 64'h5000, 64'h8, 16'h0001);
      do_op(2'd1, 1'b1, 1'b0, 5'd0, 5'd31, 64'h6000, 64'h0, 16'h0002); // rt 0 is legal
      do_op(2'd0, 1'b0, 1'b0, 5'd2, 5'd0, 64'h7000, 64'h0, 16'h0001);  // rt != ra, ra 0 illegal

      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      check64("R1 all requests seen", {32'b0, req_q.size()}, 64'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule